// File: doc/BRIEF.md
# Four-Distinct-Value Load Predictor

This block predicts the data a load instruction will return. It keeps a direct-mapped table indexed by a hash of the load's address. Every line holds four different values that earlier loads to that line returned, and a short record of which of the four slots was used on each recent access. That record is a pattern of 2-bit slot numbers, and it selects one row of a shared table of saturating confidence counters, one counter per slot. The slot with the highest counter in that row is the candidate. The block offers the candidate as a prediction only when its counter reaches a threshold supplied with the lookup.

A lookup names a line and gets its answer one cycle later. An update names a line and the value the load actually returned. If that value is already on the line, its slot counts as matched. If it is not, the value replaces the least recently matched slot. In both cases the update adjusts the counter row selected by the line's previous pattern and then shifts the slot number into the pattern. With the default parameters the table has 8 lines, values are 64 bits wide and the pattern covers the last 5 accesses. The pattern length is a parameter. Six accesses gives a 4096-row counter table.

Top module: `ldv_predictor`

## Requirements
- R1: After reset, every stored value, every line pattern and every counter is zero. Slot 0 of every line is the least recently matched slot, followed by slots 1, 2 and 3. A lookup then returns slot 0, value 0, and no prediction for any threshold of 1 or more.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. A lookup issued in the same cycle as an update observes the state from before that update.
- R3: Counters are 4 bits wide and hold values from 0 to 12. An increment at 12 leaves the counter at 12, and a decrement at 0 leaves it at 0.
- R4: `rsp_predict` is high only when `rsp_valid` is high and the chosen slot's counter is greater than or equal to `lk_thresh`, a value from 1 to 12.
- R5: The chosen slot is the one with the largest of the four counters in the row selected by the line's pattern, and a tie goes to the lower slot number. `rsp_slot` gives that slot and `rsp_value` gives the value stored in it.
- R6: When the update value equals a stored value, no stored value changes. The matching slot (the lowest one if several match) becomes the most recently matched slot.
- R7: When the update value matches no stored value, it is written into the least recently matched slot, and that slot becomes the most recently matched.
- R8: After an update, the line's pattern is the old pattern shifted left by 2 bits, with the matched or written slot number in the low 2 bits. The pattern keeps the last HIST_LEN slot numbers.
- R9: An update changes only the counter row selected by the line's pattern from before the update. On a match, the matched slot's counter goes up by one and the other three go down by one. On a miss, all four go down by one.
- R10: A line's values, recency order and pattern change only on updates that address that line. The counter table is shared by all lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | INDEX_W | Line addressed by the lookup |
| lk_thresh | input | 4 | Confidence threshold for this lookup, 1 to 12 |
| up_valid | input | 1 | Update request |
| up_index | input | INDEX_W | Line addressed by the update |
| up_value | input | VALUE_W | Value the load actually returned |
| rsp_valid | output | 1 | Lookup response present |
| rsp_predict | output | 1 | Candidate meets the threshold |
| rsp_slot | output | 2 | Slot of the candidate |
| rsp_value | output | VALUE_W | Candidate value |

## Verification
Counter saturation is tested by driving one line through long runs of a single value followed by a miss. The test then reads the counter back at thresholds 11 and 12. A counter without the cap at 12 would still predict at 12, and a counter whose decrement wraps would predict at any threshold. Same-cycle lookup and update on one line must return the state from before the update. A design that forwards the update would report a newer value or a newer slot. Replacement order and duplicate suppression are tested by filling lines with more than four distinct values and repeating values that are already stored. An LRU error, or a second copy of an existing value, shows up later as a wrong candidate value. A long mixed run compares the patterns, the shared counter rows and the tie resolution toward the lower slot against a behavioural model on every cycle.

// File: rtl/ldv_pkg.sv
package ldv_pkg;
  localparam int SLOTS   = 4;
  localparam int SLOT_W  = 2;
  localparam int CNT_W   = 4;
  localparam int CNT_MAX = 12;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/ldv_slot_select.sv
module ldv_slot_select
  import ldv_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0][CNT_W-1:0] cnts,
  output slot_t                       best,
  output cnt_t                        best_cnt
);
  // Two-level tournament; the left (lower) contender wins on equality.
  slot_t lo_slot, hi_slot;
  cnt_t  lo_cnt,  hi_cnt;

  always_comb begin
    if (cnts[0] >= cnts[1]) begin
      lo_slot = slot_t'(0);
      lo_cnt  = cnts[0];
    end else begin
      lo_slot = slot_t'(1);
      lo_cnt  = cnts[1];
    end
    if (cnts[2] >= cnts[3]) begin
      hi_slot = slot_t'(2);
      hi_cnt  = cnts[2];
    end else begin
      hi_slot = slot_t'(3);
      hi_cnt  = cnts[3];
    end
    if (lo_cnt >= hi_cnt) begin
      best     = lo_slot;
      best_cnt = lo_cnt;
    end else begin
      best     = hi_slot;
      best_cnt = hi_cnt;
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_chk
    // R5: no counter in the row beats the winner
    a_r5_winner_is_max: assert property (@(posedge clk) disable iff (!rst_n)
      cnts[j] <= best_cnt);
    // R5: a lower slot never ties the winner
    a_r5_tie_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_t'(j) < best) |-> (cnts[j] < best_cnt));
  end
endmodule

// File: rtl/ldv_conf_table.sv
module ldv_conf_table
  import ldv_pkg::*;
#(
  parameter int PAT_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PAT_W-1:0]            rd_pat,
  output logic [SLOTS-1:0][CNT_W-1:0] rd_cnts,
  input  logic                        wr_en,
  input  logic [PAT_W-1:0]            wr_pat,
  input  logic                        wr_hit,
  input  slot_t                       wr_slot
);
  localparam int   DEPTH = 1 << PAT_W;
  localparam cnt_t TOP   = cnt_t'(CNT_MAX);

  logic [SLOTS-1:0][CNT_W-1:0] ctr_q [DEPTH];
  logic [SLOTS-1:0][CNT_W-1:0] cur_row;
  logic [SLOTS-1:0][CNT_W-1:0] row_d;

  assign rd_cnts = ctr_q[rd_pat];
  assign cur_row = ctr_q[wr_pat];

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      if (wr_hit && (wr_slot == slot_t'(j))) begin
        row_d[j] = (cur_row[j] >= TOP) ? TOP : cur_row[j] + cnt_t'(1);
      end else begin
        row_d[j] = (cur_row[j] == '0) ? '0 : cur_row[j] - cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < DEPTH; p++) begin
        ctr_q[p] <= '0;
      end
    end else if (wr_en) begin
      ctr_q[wr_pat] <= row_d;
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_chk
    // R3: a counter read for a lookup never exceeds the cap
    a_r3_ctr_cap: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnts[j] <= TOP);
    // R9: a matched counter below the cap rises by exactly one
    a_r9_hit_increments: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hit && (wr_slot == slot_t'(j)) && (cur_row[j] < TOP))
      |=> (ctr_q[$past(wr_pat)][j] == $past(cur_row[j]) + cnt_t'(1)));
  end
endmodule

// File: rtl/ldv_line_store.sv
module ldv_line_store
  import ldv_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int VALUE_W = 64,
  parameter int PAT_W   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [INDEX_W-1:0]            rd_idx,
  output logic [SLOTS-1:0][VALUE_W-1:0] rd_vals,
  output logic [PAT_W-1:0]              rd_pat,
  input  logic                          wr_en,
  input  logic [INDEX_W-1:0]            wr_idx,
  input  logic [VALUE_W-1:0]            wr_value,
  output logic [PAT_W-1:0]              upd_pat,
  output logic                          upd_hit,
  output slot_t                         upd_slot
);
  localparam int    LINES  = 1 << INDEX_W;
  localparam slot_t OLDEST = slot_t'(SLOTS - 1);

  logic [SLOTS-1:0][VALUE_W-1:0] val_q [LINES];
  logic [SLOTS-1:0][SLOT_W-1:0]  age_q [LINES];
  logic [PAT_W-1:0]              pat_q [LINES];

  logic [SLOTS-1:0][VALUE_W-1:0] cur_vals, vals_d;
  logic [SLOTS-1:0][SLOT_W-1:0]  cur_age, age_d;
  logic [PAT_W-1:0]              pat_d;
  logic [SLOTS-1:0]              eq;
  slot_t                         hit_slot, victim;

  assign rd_vals  = val_q[rd_idx];
  assign rd_pat   = pat_q[rd_idx];
  assign cur_vals = val_q[wr_idx];
  assign cur_age  = age_q[wr_idx];
  assign upd_pat  = pat_q[wr_idx];

  for (genvar j = 0; j < SLOTS; j++) begin : g_cmp
    assign eq[j] = (cur_vals[j] == wr_value);
  end

  always_comb begin
    hit_slot = '0;
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if (eq[j]) hit_slot = slot_t'(j);
    end
    victim = '0;
    for (int j = 0; j < SLOTS; j++) begin
      if (cur_age[j] == OLDEST) victim = slot_t'(j);
    end
    upd_hit  = |eq;
    upd_slot = upd_hit ? hit_slot : victim;
  end

  always_comb begin
    vals_d = cur_vals;
    if (!upd_hit) vals_d[upd_slot] = wr_value;
    for (int j = 0; j < SLOTS; j++) begin
      if (slot_t'(j) == upd_slot) begin
        age_d[j] = '0;
      end else if (cur_age[j] < cur_age[upd_slot]) begin
        age_d[j] = cur_age[j] + slot_t'(1);
      end else begin
        age_d[j] = cur_age[j];
      end
    end
  end

  if (PAT_W > SLOT_W) begin : g_shift
    assign pat_d = {upd_pat[PAT_W-SLOT_W-1:0], upd_slot};
  end else begin : g_single
    assign pat_d = upd_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) begin
        val_q[l] <= '0;
        pat_q[l] <= '0;
        for (int j = 0; j < SLOTS; j++) begin
          age_q[l][j] <= slot_t'(SLOTS - 1 - j);
        end
      end
    end else if (wr_en) begin
      val_q[wr_idx] <= vals_d;
      age_q[wr_idx] <= age_d;
      pat_q[wr_idx] <= pat_d;
    end
  end

  logic [SLOTS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int j = 0; j < SLOTS; j++) age_seen[cur_age[j]] = 1'b1;
  end

  // R7: recency ranks of the updated line form a permutation
  a_r7_ranks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (&age_seen));
  // R7: a miss always lands on the least recently matched slot
  a_r7_victim_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !upd_hit) |-> (cur_age[upd_slot] == OLDEST));
  // R6: a matching update leaves the stored values untouched
  a_r6_hit_keeps_values: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && upd_hit) |=> (val_q[$past(wr_idx)] == $past(cur_vals)));
endmodule

// File: rtl/ldv_predictor.sv
module ldv_predictor
  import ldv_pkg::*;
#(
  parameter int INDEX_W  = 3,
  parameter int VALUE_W  = 64,
  parameter int HIST_LEN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [INDEX_W-1:0] lk_index,
  input  logic [CNT_W-1:0]   lk_thresh,
  input  logic               up_valid,
  input  logic [INDEX_W-1:0] up_index,
  input  logic [VALUE_W-1:0] up_value,
  output logic               rsp_valid,
  output logic               rsp_predict,
  output logic [SLOT_W-1:0]  rsp_slot,
  output logic [VALUE_W-1:0] rsp_value
);
  localparam int PAT_W = SLOT_W * HIST_LEN;

  logic [SLOTS-1:0][VALUE_W-1:0] rd_vals;
  logic [PAT_W-1:0]              rd_pat, upd_pat;
  logic [SLOTS-1:0][CNT_W-1:0]   rd_cnts;
  logic                          upd_hit;
  slot_t                         upd_slot, best;
  cnt_t                          best_cnt;

  ldv_line_store #(
    .INDEX_W (INDEX_W),
    .VALUE_W (VALUE_W),
    .PAT_W   (PAT_W)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_index),
    .rd_vals  (rd_vals),
    .rd_pat   (rd_pat),
    .wr_en    (up_valid),
    .wr_idx   (up_index),
    .wr_value (up_value),
    .upd_pat  (upd_pat),
    .upd_hit  (upd_hit),
    .upd_slot (upd_slot)
  );

  ldv_conf_table #(
    .PAT_W (PAT_W)
  ) u_conf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_pat  (rd_pat),
    .rd_cnts (rd_cnts),
    .wr_en   (up_valid),
    .wr_pat  (upd_pat),
    .wr_hit  (upd_hit),
    .wr_slot (upd_slot)
  );

  ldv_slot_select u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnts     (rd_cnts),
    .best     (best),
    .best_cnt (best_cnt)
  );

  logic               valid_d, predict_d;
  slot_t              slot_d;
  logic [VALUE_W-1:0] value_d;

  always_comb begin
    valid_d   = lk_valid;
    predict_d = lk_valid && (best_cnt >= lk_thresh);
    slot_d    = rsp_slot;
    value_d   = rsp_value;
    if (lk_valid) begin
      slot_d  = best;
      value_d = rd_vals[best];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_predict <= 1'b0;
      rsp_slot    <= '0;
      rsp_value   <= '0;
    end else begin
      rsp_valid   <= valid_d;
      rsp_predict <= predict_d;
      rsp_slot    <= slot_d;
      rsp_value   <= value_d;
    end
  end

  // R2: every lookup is answered on the next cycle
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R2: no response without a lookup the cycle before
  a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R4: a prediction only accompanies a valid response
  a_r4_predict_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_predict |-> rsp_valid);
endmodule

// File: tb/ldv_predictor_test.sv
module ldv_predictor_test;
  localparam int IW    = 3;
  localparam int VW    = 64;
  localparam int HL    = 5;
  localparam int LINES = 1 << IW;
  localparam int NPAT  = 1 << (2 * HL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [IW-1:0] lk_index = '0;
  logic [3:0]    lk_thresh = 4'd1;
  logic          up_valid = 1'b0;
  logic [IW-1:0] up_index = '0;
  logic [VW-1:0] up_value = '0;
  logic          rsp_valid, rsp_predict;
  logic [1:0]    rsp_slot;
  logic [VW-1:0] rsp_value;

  ldv_predictor #(.INDEX_W(IW), .VALUE_W(VW), .HIST_LEN(HL)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_index(lk_index),
    .lk_thresh(lk_thresh), .up_valid(up_valid), .up_index(up_index),
    .up_value(up_value), .rsp_valid(rsp_valid), .rsp_predict(rsp_predict),
    .rsp_slot(rsp_slot), .rsp_value(rsp_value)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] m_val [LINES][4];
  int          m_ord [LINES][$];   // most recently matched first
  int          m_pat [LINES];
  int          m_ctr [NPAT][4];

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int l = 0; l < LINES; l++) begin
      for (int j = 0; j < 4; j++) m_val[l][j] = '0;
      m_ord[l] = {3, 2, 1, 0};
      m_pat[l] = 0;
    end
    for (int p = 0; p < NPAT; p++)
      for (int j = 0; j < 4; j++) m_ctr[p][j] = 0;
  endtask

  task automatic m_update(input int idx, input logic [63:0] v);
    int slot;
    int p;
    bit hit;
    slot = -1;
    p = m_pat[idx];
    for (int j = 0; j < 4; j++)
      if (slot < 0 && m_val[idx][j] == v) slot = j;
    hit = (slot >= 0);
    if (!hit) slot = m_ord[idx][3];
    for (int j = 0; j < 4; j++) begin
      if (hit && j == slot) begin
        if (m_ctr[p][j] < 12) m_ctr[p][j]++;
      end else if (m_ctr[p][j] > 0) begin
        m_ctr[p][j]--;
      end
    end
    for (int k = 0; k < 4; k++) begin
      if (m_ord[idx][k] == slot) begin
        m_ord[idx].delete(k);
        break;
      end
    end
    m_ord[idx].push_front(slot);
    if (!hit) m_val[idx][slot] = v;
    m_pat[idx] = ((p << 2) | slot) & (NPAT - 1);
  endtask

  // one clock cycle: drive at the falling edge, compare after the rising edge
  task automatic cyc(input bit lv, input int li, input bit uv, input int ui,
                     input logic [63:0] uval, input int thr, input string tag);
    int p;
    int best;
    bit epred;
    logic [63:0] evalue;
    best = 0;
    epred = 0;
    evalue = '0;
    lk_valid  = lv;
    lk_index  = IW'(li);
    lk_thresh = 4'(thr);
    up_valid  = uv;
    up_index  = IW'(ui);
    up_value  = uval;
    if (lv) begin
      p = m_pat[li];
      for (int j = 1; j < 4; j++)
        if (m_ctr[p][j] > m_ctr[p][best]) best = j;
      epred  = (m_ctr[p][best] >= thr);
      evalue = m_val[li][best];
    end
    if (uv) m_update(ui, uval);
    @(posedge clk);
    #1;
    chk({"R2 response valid ", tag}, 64'(rsp_valid), 64'(lv));
    if (lv) begin
      chk({"R4 predict decision ", tag}, 64'(rsp_predict), 64'(epred));
      chk({"R5 chosen slot ", tag}, 64'(rsp_slot), 64'(best));
      chk({"R5 candidate value ", tag}, rsp_value, evalue);
    end
    @(negedge clk);
    lk_valid = 1'b0;
    up_valid = 1'b0;
  endtask

  function automatic logic [63:0] pool(input int k);
    return (k == 0) ? 64'd0 : (64'hC0DE_0000_0000_0000 | 64'(k * 37));
  endfunction

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 no response during reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no response before any lookup", 64'(rsp_valid), 64'd0);

    // R1: fresh lines answer slot 0, value 0, no prediction
    for (int l = 0; l < LINES; l++) cyc(1, l, 0, 0, '0, 1, "R1 reset lookup");
    chk("R1 reset candidate is zero", rsp_value, 64'd0);

    // R3: saturation at twelve on line 2
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 2, pool(1), 12, "R3 build");
    cyc(1, 2, 0, 0, '0, 12, "R3 below cap");
    chk("R3 count 11 misses threshold 12", 64'(rsp_predict), 64'd0);
    cyc(0, 0, 1, 2, pool(1), 12, "R3 build");
    cyc(1, 2, 0, 0, '0, 12, "R3 at cap");
    chk("R3 count 12 meets threshold 12", 64'(rsp_predict), 64'd1);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 2, pool(1), 12, "R3 hold");
    cyc(0, 0, 1, 2, pool(2), 12, "R3 miss");
    for (int i = 0; i < HL; i++) cyc(0, 0, 1, 2, pool(1), 12, "R3 refill");
    cyc(1, 2, 0, 0, '0, 12, "R3 after one decrement");
    chk("R3 capped counter drops to 11", 64'(rsp_predict), 64'd0);
    cyc(1, 2, 0, 0, '0, 11, "R3 after one decrement");
    chk("R3 counter 11 meets threshold 11", 64'(rsp_predict), 64'd1);

    // R6: repeat a stored value, then confirm the other stored value survives
    cyc(0, 0, 1, 2, pool(2), 4, "R6 duplicate");
    cyc(1, 2, 0, 0, '0, 4, "R6 duplicate");
    chk("R6 duplicated value stays in slot 1", m_val[2][1], pool(2));

    // R7: more than four distinct values on line 5
    for (int i = 0; i < 7; i++) begin
      cyc(1, 5, 1, 5, pool(10 + i), 3, "R7 victim order");
    end

    // R8 R9: alternating pair on line 6 builds pattern-specific confidence
    for (int i = 0; i < 40; i++) begin
      cyc(1, 6, 0, 0, '0, 4, "R8 R9 alternating");
      cyc(0, 0, 1, 6, pool(20 + (i % 2)), 4, "R8 R9 alternating");
    end

    // R2: lookup and update on the same line in the same cycle
    for (int i = 0; i < 6; i++) cyc(1, 6, 1, 6, pool(30 + i), 1, "R2 same-cycle");

    // R10: updates to line 1 leave line 3 values alone
    for (int i = 0; i < 10; i++) cyc(1, 3, 1, 1, pool(40 + i), 1, "R10 independence");

    // mixed run against the model
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 10) < 6, $urandom % 4, ($urandom % 10) < 7, $urandom % 4,
          pool($urandom % 6), 1 + ($urandom % 12), "R5 R6 R7 R8 R9 mixed");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule